// File: doc/BRIEF.md
# Memory Card Host Byte-Lane Decoder

This block sits on the card side of a removable memory card that has a 16-bit host data path. It decodes the host's active-low strobes: two card enables, one for each byte lane, plus an output enable and a write enable. It also takes an attribute-select input and the lowest address bit. From these it steers bytes between the host data bus and an internal 16-bit memory port. Each access goes either to the common memory plane or to the attribute register plane. When the even-lane enable is used alone, the low address bit picks which byte of the word appears on the low host lane. This lets an 8-bit host reach every byte.

The internal port is split in two. A combinational read side has a read strobe, a plane flag, byte enables and a data input. A registered write side issues exactly one strobe pulse for each falling edge of the host write enable. Writes to the common plane are dropped while the write-protect switch is on or while the array reports busy. The attribute plane stays writable in both cases.

The status outputs are plain levels: ready, write-protect status, a wait output tied inactive, and a power-down flag. The active-high reset holds the block in its power-on default state with the array powered down. The interface has no valid/ready handshake, because the host strobes set the transfer timing and the card never stalls the host.

Top module: `card_lane_decoder`

## Requirements
- R1: With both card enables low (word mode), a0 has no effect. A read drives all 16 bits (host_doe = 2'b11, host_dout = rd_data, bit 15 most significant) and rd_be = 2'b11.
- R2: With only ce_even_n low and a0 = 0, a read places rd_data[7:0] on host_dout[7:0], host_doe = 2'b01 and rd_be = 2'b01.
- R3: With only ce_even_n low and a0 = 1, a read places rd_data[15:8] on host_dout[7:0], host_doe = 2'b01 and rd_be = 2'b10.
- R4: With only ce_odd_n low, a read places rd_data[15:8] on host_dout[15:8], host_doe = 2'b10 and rd_be = 2'b10. The low lane is left undriven.
- R5: Lanes are driven and rd_en is high only while oe_n is low and we_n is high. Undriven lanes read as zero on host_dout.
- R6: attr_n low routes a read or write to the attribute plane (rd_attr / wr_attr = 1). attr_n high routes it to the common plane (flag = 0).
- R7: Each falling edge of we_n seen while a card enable is low produces exactly one wr_en pulse on the next cycle. The pulse carries byte enables that follow the R1–R4 lane rules. The data is host_din in word mode, {host_din[7:0], host_din[7:0]} for even-only access and {host_din[15:8], host_din[15:8]} for odd-only access.
- R8: While wp_switch is high, no wr_en pulse occurs for the common plane, and wp_status follows wp_switch. Attribute-plane writes still go through.
- R9: While dev_busy is high, ready is low and common-plane writes are dropped.
- R10: With both card enables high, host_doe = 0, rd_en = 0 and no wr_en pulse follows.
- R11: While rst is high, pwr_down = 1, ready = 0 and no read or write strobe is issued. pwr_down clears on the first clock edge after rst falls. wait_n is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Active-high reset; power-on default and power-down |
| ce_even_n | input | 1 | Even byte lane enable, active low |
| ce_odd_n | input | 1 | Odd byte lane enable, active low |
| oe_n | input | 1 | Read gate, active low |
| we_n | input | 1 | Write gate, active low |
| attr_n | input | 1 | Attribute plane select, active low |
| a0 | input | 1 | Low address bit, byte pick in even-only access |
| host_din | input | 16 | Data from the host bus |
| host_dout | output | 16 | Data toward the host bus |
| host_doe | output | 2 | Per-lane drive enable (bit 0 = DQ7:0, bit 1 = DQ15:8) |
| rd_en | output | 1 | Internal read strobe |
| rd_attr | output | 1 | Read targets attribute plane |
| rd_be | output | 2 | Read byte enables |
| rd_data | input | 16 | Word from the selected plane |
| wr_en | output | 1 | Internal write strobe, one cycle |
| wr_attr | output | 1 | Write targets attribute plane |
| wr_be | output | 2 | Write byte enables |
| wr_data | output | 16 | Steered write word |
| dev_busy | input | 1 | Array busy with a timed erase or program |
| wp_switch | input | 1 | Write-protect switch, high = protected |
| ready | output | 1 | High when accesses can be accepted |
| wp_status | output | 1 | Reflects the write-protect switch |
| wait_n | output | 1 | Wait request, always inactive (high) |
| pwr_down | output | 1 | Array held in power-down |

## Verification
The assertions check the following on every cycle:
- An idle card neither drives the bus nor strobes the port.
- Byte modes never drive both lanes.
- Every drive is backed by a read strobe.
- A write strobe lasts a single cycle.
- No common-plane write follows a cycle with protection or busy.
- Power-down suppresses reads.

Only the bench scenarios can show that the right byte lands in the right lane, and that a0 is ignored in word mode. They also show that dropped writes leave the stored word unchanged when it is read back afterwards, and that attribute and common data stay separate.

// File: rtl/card_lane_pkg.sv
package card_lane_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WORD = 2'd1,
    MODE_EVEN = 2'd2,
    MODE_ODD  = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/card_lane_steer.sv
module card_lane_steer
  import card_lane_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic          ce_even_n,
  input  logic          ce_odd_n,
  input  logic          a0,
  input  logic          rd_ok,
  input  logic [DW-1:0] host_din,
  input  logic [DW-1:0] rd_data,
  output lane_mode_e    mode,
  output logic          active,
  output logic          rd_en,
  output logic [1:0]    lane_be,
  output logic [DW-1:0] host_dout,
  output logic [1:0]    host_doe,
  output logic [DW-1:0] wr_steer
);
  localparam logic [BYTE_W-1:0] ZB = '0;

  always_comb begin
    unique case ({ce_odd_n, ce_even_n})
      2'b00:   mode = MODE_WORD;
      2'b10:   mode = MODE_EVEN;
      2'b01:   mode = MODE_ODD;
      default: mode = MODE_IDLE;
    endcase
  end

  assign active = (mode != MODE_IDLE);
  assign rd_en  = active & rd_ok;

  always_comb begin
    lane_be   = 2'b00;
    host_dout = '0;
    host_doe  = 2'b00;
    wr_steer  = '0;
    unique case (mode)
      MODE_WORD: begin
        lane_be   = 2'b11;
        host_dout = rd_data;
        host_doe  = 2'b11;
        wr_steer  = host_din;
      end
      MODE_EVEN: begin
        lane_be   = a0 ? 2'b10 : 2'b01;
        host_dout = a0 ? {ZB, rd_data[DW-1:BYTE_W]} : {ZB, rd_data[BYTE_W-1:0]};
        host_doe  = 2'b01;
        wr_steer  = {host_din[BYTE_W-1:0], host_din[BYTE_W-1:0]};
      end
      MODE_ODD: begin
        lane_be   = 2'b10;
        host_dout = {rd_data[DW-1:BYTE_W], ZB};
        host_doe  = 2'b10;
        wr_steer  = {host_din[DW-1:BYTE_W], host_din[DW-1:BYTE_W]};
      end
      default: ;
    endcase
    if (!rd_ok) begin
      host_dout = '0;
      host_doe  = 2'b00;
    end
  end
endmodule

// File: rtl/card_write_gate.sv
module card_write_gate #(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_n,
  input  logic          active,
  input  logic          attr_sel,
  input  logic          pd,
  input  logic          wp_i,
  input  logic          busy_i,
  input  logic [1:0]    lane_be,
  input  logic [DW-1:0] wr_steer,
  output logic          wr_en,
  output logic          wr_attr,
  output logic [1:0]    wr_be,
  output logic [DW-1:0] wr_data
);
  logic we_q;
  logic fall;
  logic accept;

  assign fall   = we_q & ~we_n;
  assign accept = fall & active & ~pd & (attr_sel | (~wp_i & ~busy_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b1;
      wr_en   <= 1'b0;
      wr_attr <= 1'b0;
      wr_be   <= 2'b00;
      wr_data <= '0;
    end else begin
      we_q  <= we_n;
      wr_en <= accept;
      if (accept) begin
        wr_attr <= attr_sel;
        wr_be   <= lane_be;
        wr_data <= wr_steer;
      end
    end
  end

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R7

  AST_ARRAY_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_attr) |-> $past(!wp_i && !busy_i)); // R8
endmodule

// File: rtl/card_status.sv
module card_status (
  input  logic clk,
  input  logic rst,
  input  logic dev_busy,
  output logic pd,
  output logic ready
);
  always_ff @(posedge clk) begin
    if (rst) pd <= 1'b1;
    else     pd <= 1'b0;
  end

  assign ready = ~pd & ~dev_busy;
endmodule

// File: rtl/card_lane_decoder.sv
module card_lane_decoder
  import card_lane_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_even_n,
  input  logic          ce_odd_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          attr_n,
  input  logic          a0,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic [1:0]    host_doe,
  output logic          rd_en,
  output logic          rd_attr,
  output logic [1:0]    rd_be,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic          wr_attr,
  output logic [1:0]    wr_be,
  output logic [DW-1:0] wr_data,
  input  logic          dev_busy,
  input  logic          wp_switch,
  output logic          ready,
  output logic          wp_status,
  output logic          wait_n,
  output logic          pwr_down
);
  lane_mode_e    mode;
  logic          active;
  logic          pd;
  logic          rd_ok;
  logic [1:0]    lane_be;
  logic [DW-1:0] wr_steer;

  assign rd_ok = ~oe_n & we_n & ~pd & ~rst;

  card_status u_status (
    .clk      (clk),
    .rst      (rst),
    .dev_busy (dev_busy),
    .pd       (pd),
    .ready    (ready)
  );

  card_lane_steer #(.BYTE_W(BYTE_W)) u_steer (
    .ce_even_n (ce_even_n),
    .ce_odd_n  (ce_odd_n),
    .a0        (a0),
    .rd_ok     (rd_ok),
    .host_din  (host_din),
    .rd_data   (rd_data),
    .mode      (mode),
    .active    (active),
    .rd_en     (rd_en),
    .lane_be   (lane_be),
    .host_dout (host_dout),
    .host_doe  (host_doe),
    .wr_steer  (wr_steer)
  );

  card_write_gate #(.BYTE_W(BYTE_W)) u_wgate (
    .clk      (clk),
    .rst      (rst),
    .we_n     (we_n),
    .active   (active),
    .attr_sel (~attr_n),
    .pd       (pd),
    .wp_i     (wp_switch),
    .busy_i   (dev_busy),
    .lane_be  (lane_be),
    .wr_steer (wr_steer),
    .wr_en    (wr_en),
    .wr_attr  (wr_attr),
    .wr_be    (wr_be),
    .wr_data  (wr_data)
  );

  assign rd_attr   = ~attr_n;
  assign rd_be     = rd_en ? lane_be : 2'b00;
  assign wp_status = wp_switch;
  assign wait_n    = 1'b1;
  assign pwr_down  = pd;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (ce_even_n && ce_odd_n) |-> (host_doe == 2'b00 && !rd_en)); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ce_even_n && ce_odd_n) |=> !wr_en); // R10

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (ce_even_n || ce_odd_n) |-> $onehot0(host_doe)); // R4

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    (host_doe != 2'b00) |-> (rd_en && !oe_n && we_n)); // R5

  AST_PD_NO_READ: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (!rd_en && host_doe == 2'b00 && !ready)); // R11
endmodule

// File: tb/card_lane_decoder_bench.sv
module card_lane_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_even_n = 1'b1, ce_odd_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, attr_n = 1'b1, a0 = 1'b0;
  logic [DW-1:0] host_din = '0;
  logic [DW-1:0] host_dout, rd_data, wr_data;
  logic [1:0] host_doe, rd_be, wr_be;
  logic rd_en, rd_attr, wr_en, wr_attr, ready, wp_status, wait_n, pwr_down;
  logic dev_busy = 1'b0, wp_switch = 1'b0;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] mem_common = 16'h0000, mem_attr = 16'h0000;
  logic [DW-1:0] exp_common = 16'h0000, exp_attr = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_lane_decoder u_card_lane_decoder (
    .clk(clk), .rst(rst), .ce_even_n(ce_even_n), .ce_odd_n(ce_odd_n),
    .oe_n(oe_n), .we_n(we_n), .attr_n(attr_n), .a0(a0), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .rd_en(rd_en), .rd_attr(rd_attr),
    .rd_be(rd_be), .rd_data(rd_data), .wr_en(wr_en), .wr_attr(wr_attr),
    .wr_be(wr_be), .wr_data(wr_data), .dev_busy(dev_busy), .wp_switch(wp_switch),
    .ready(ready), .wp_status(wp_status), .wait_n(wait_n), .pwr_down(pwr_down)
  );

  // Memory environment: two one-word planes.
  assign rd_data = rd_attr ? mem_attr : mem_common;
  always @(posedge clk) begin
    if (wr_en) begin
      if (wr_attr) begin
        if (wr_be[0]) mem_attr[7:0]  <= wr_data[7:0];
        if (wr_be[1]) mem_attr[15:8] <= wr_data[15:8];
      end else begin
        if (wr_be[0]) mem_common[7:0]  <= wr_data[7:0];
        if (wr_be[1]) mem_common[15:8] <= wr_data[15:8];
      end
    end
  end

  // mode: 0 idle, 1 word, 2 even only, 3 odd only
  function automatic logic [1:0] f_be(input int m, input logic a);
    case (m)
      1: f_be = 2'b11;
      2: f_be = a ? 2'b10 : 2'b01;
      3: f_be = 2'b10;
      default: f_be = 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] f_doe(input int m);
    case (m)
      1: f_doe = 2'b11;
      2: f_doe = 2'b01;
      3: f_doe = 2'b10;
      default: f_doe = 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] f_dout(input int m, input logic a, input logic [15:0] w);
    case (m)
      1: f_dout = w;
      2: f_dout = a ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
      3: f_dout = {w[15:8], 8'h00};
      default: f_dout = 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] f_wdata(input int m, input logic [15:0] d);
    case (m)
      1: f_wdata = d;
      2: f_wdata = {d[7:0], d[7:0]};
      3: f_wdata = {d[15:8], d[15:8]};
      default: f_wdata = 16'h0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    ce_even_n = !(m == 1 || m == 2);
    ce_odd_n  = !(m == 1 || m == 3);
  endtask

  task automatic do_read(input int m, input logic a, input logic at, input string req);
    logic [15:0] w;
    @(negedge clk);
    set_mode(m); a0 = a; attr_n = !at; we_n = 1'b1; oe_n = 1'b0;
    #1;
    w = at ? exp_attr : exp_common;
    check(host_doe == f_doe(m) && host_dout == f_dout(m, a, w) &&
          rd_en == (m != 0) && rd_be == f_be(m, a) && (m == 0 || rd_attr == at),
          req, {14'd0, host_doe, host_dout, 13'd0, rd_en, rd_be, 15'd0, rd_attr},
          {14'd0, f_doe(m), f_dout(m, a, w), 13'd0, (m != 0), f_be(m, a), 15'd0, at});
    @(negedge clk);
    oe_n = 1'b1;
  endtask

  task automatic do_write(input int m, input logic a, input logic at, input logic [15:0] d, input string req);
    bit acc;
    logic [1:0] be;
    logic [15:0] wd;
    @(negedge clk);
    set_mode(m); a0 = a; attr_n = !at; oe_n = 1'b1; host_din = d; we_n = 1'b0;
    acc = (m != 0) && (at || (!wp_switch && !dev_busy));
    be = f_be(m, a);
    wd = f_wdata(m, d);
    @(negedge clk);
    check(wr_en == acc && (!acc || (wr_be == be && wr_data == wd && wr_attr == at)),
          req, {15'd0, wr_en, 14'd0, wr_be, wr_data, 15'd0, wr_attr},
          {15'd0, acc, 14'd0, be, wd, 15'd0, at});
    if (acc) begin
      if (at) begin
        if (be[0]) exp_attr[7:0] = wd[7:0];
        if (be[1]) exp_attr[15:8] = wd[15:8];
      end else begin
        if (be[0]) exp_common[7:0] = wd[7:0];
        if (be[1]) exp_common[15:8] = wd[15:8];
      end
    end
    we_n = 1'b1;
    @(negedge clk);
    check(!wr_en, "R7 single pulse", {63'd0, wr_en}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    // R11 reset state with word read requested
    set_mode(1); oe_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pwr_down && !ready && wait_n && host_doe == 2'b00 && !rd_en,
          "R11 reset state", {59'd0, pwr_down, ready, wait_n, host_doe}, {59'd0, 1'b1, 1'b0, 1'b1, 2'b00});
    rst = 1'b0;
    set_mode(0); oe_n = 1'b1;
    @(negedge clk);
    check(!pwr_down && ready && wait_n, "R11 power-down released",
          {61'd0, pwr_down, ready, wait_n}, {61'd0, 3'b011});

    // directed lane cases
    do_write(1, 1'b0, 1'b0, 16'hA55A, "R1 word write");
    do_read(1, 1'b1, 1'b0, "R1 word read a0 ignored");
    do_read(2, 1'b0, 1'b0, "R2 even low byte");
    do_read(2, 1'b1, 1'b0, "R3 even high byte on low lane");
    do_read(3, 1'b0, 1'b0, "R4 odd byte on high lane");
    do_write(2, 1'b1, 1'b0, 16'h00C3, "R3 even write a0=1");
    do_read(1, 1'b0, 1'b0, "R3 readback");
    do_write(3, 1'b0, 1'b0, 16'h7E00, "R4 odd write");
    do_read(1, 1'b0, 1'b0, "R4 readback");
    do_write(1, 1'b0, 1'b1, 16'h1234, "R6 attribute write");
    do_read(1, 1'b0, 1'b1, "R6 attribute readback");
    do_read(1, 1'b0, 1'b0, "R6 common untouched");
    do_write(0, 1'b0, 1'b0, 16'hFFFF, "R10 idle write dropped");
    do_read(0, 1'b0, 1'b0, "R10 idle no drive");

    // R5: oe low with we low drives nothing
    @(negedge clk);
    set_mode(1); oe_n = 1'b0; we_n = 1'b0; attr_n = 1'b1;
    #1;
    check(host_doe == 2'b00 && !rd_en, "R5 no drive during write", {61'd0, rd_en, host_doe}, 64'd0);
    @(negedge clk);
    oe_n = 1'b1; we_n = 1'b1; set_mode(0);
    exp_common = (wp_switch || dev_busy) ? exp_common : host_din;
    @(negedge clk);

    // R8 / R9 directed
    wp_switch = 1'b1;
    #1;
    check(wp_status == 1'b1, "R8 wp_status follows", {63'd0, wp_status}, 64'd1);
    do_write(1, 1'b0, 1'b0, 16'hDEAD, "R8 protected array write dropped");
    do_write(1, 1'b0, 1'b1, 16'hBEEF, "R8 attribute write allowed under protect");
    do_read(1, 1'b0, 1'b0, "R8 array unchanged");
    wp_switch = 1'b0;
    dev_busy = 1'b1;
    #1;
    check(!ready, "R9 busy clears ready", {63'd0, ready}, 64'd0);
    do_write(2, 1'b0, 1'b0, 16'h0011, "R9 busy array write dropped");
    do_read(1, 1'b0, 1'b0, "R9 array unchanged");
    dev_busy = 1'b0;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int m;
      logic a, at;
      logic [15:0] d;
      m = int'($urandom_range(0, 3));
      a = 1'($urandom_range(0, 1));
      at = 1'($urandom_range(0, 1));
      d = 16'($urandom);
      wp_switch = ($urandom_range(0, 3) == 0);
      dev_busy = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 0) do_write(m, a, at, d, "R7 random write");
      else do_read(m, a, at, "R1 random read");
    end
    wp_switch = 1'b0; dev_busy = 1'b0;
    do_read(1, 1'b0, 1'b0, "R7 final common");
    do_read(1, 1'b0, 1'b1, "R6 final attribute");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule